// File: doc/BRIEF.md
# Codec Link Frame Serializer

This block is the controller end of a slot-based, full-duplex serial link to an audio codec. It runs entirely on the bit clock that the codec supplies. Each frame is 256 bit clocks long and holds 13 slots: a 16-bit tag slot followed by twelve 20-bit slots. At 12.288 MHz this gives a 48 kHz frame rate. The block drives a frame sync that marks the tag slot and shifts the outgoing slots out on the serial output. In the same frame it assembles the incoming slots from the serial input.

Parallel transmit values are taken once, at the first bit of each frame. A full received frame is presented on parallel outputs together with a one-clock valid strobe. This happens on the clock that starts the following frame. The block also drives the active-low codec reset from an enable input. While that reset is asserted the link is kept silent.

Top module: `aclink_frame_ser`

## Requirements
- R1: While the link is running, a frame lasts exactly 256 bit clocks. The frame sync rises once every 256 clocks.
- R2: Sync is high for bit positions 0 to 15 of each frame (the tag slot) and low for positions 16 to 255.
- R3: The outgoing frame is sent MSB first: the 16-bit `tx_tag` first, then slots 1 to 12 in order, 20 bits each. Slot k is taken from `tx_data[(k-1)*20 +: 20]`. Slot boundaries therefore fall at bit positions 16, 36, 56, ..., 236.
- R4: `sync` and `sdo` are registered on the rising bit-clock edge. Bit position p becomes visible just after the rising edge at which the internal position equals p. The first bit after enable is position 0.
- R5: `sdi` is sampled on the falling bit-clock edge. The received bits use the same layout as R3: the tag goes to `rx_tag` and slot k to `rx_data[(k-1)*20 +: 20]`.
- R6: `tx_tag` and `tx_data` are captured only on the rising edge that emits bit 0. Changes at any other time do not affect the frame in progress.
- R7: `rx_valid` is high for one clock after the rising edge that emits bit 0 of a frame, and only when the whole previous frame of 256 bits was received while the link was running. `rx_tag` and `rx_data` update at that same edge.
- R8: `codec_rst_n` follows `link_en` one rising edge later. While it is low, `sync` and `sdo` are low, the frame position is cleared, and no partial frame is published.
- R9: While `rst_n` is low, all outputs are low. Release of `rst_n` is synchronised over two bit-clock edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bclk | input | 1 | Bit clock from the codec |
| rst_n | input | 1 | Asynchronous active-low reset |
| link_en | input | 1 | Enable; releases the codec reset |
| tx_tag | input | 16 | Outgoing tag slot |
| tx_data | input | 240 | Outgoing slots 1..12, slot k at [(k-1)*20 +: 20] |
| sdi | input | 1 | Serial data from the codec |
| sync | output | 1 | Frame sync |
| sdo | output | 1 | Serial data to the codec |
| codec_rst_n | output | 1 | Active-low codec reset |
| rx_tag | output | 16 | Received tag slot |
| rx_data | output | 240 | Received slots 1..12 |
| rx_valid | output | 1 | One-clock strobe for a new received frame |

## Verification
The bench checks `sync` and `sdo` for bit p just after the same rising edge that steps the position to p. `codec_rst_n` is expected exactly one edge after `link_en` changes. A received bit driven after edge p is captured at the following falling edge. It therefore shows up in the published frame only at the bit-0 edge of the next frame, 256 edges after its own frame began. The bench's behavioural model keeps the driven input bits in a queue. It latches transmit values only at its own bit-0 step and compares every output 1 ns after each rising edge. It drives stimulus 3 ns after the edge and drives `sdi` 1 ns after the edge, so every value is settled before the falling sample point.

// File: rtl/aclink_pkg.sv
package aclink_pkg;
  localparam int unsigned DEF_NSLOT   = 13;
  localparam int unsigned DEF_SLOT0_W = 16;
  localparam int unsigned DEF_SLOT_W  = 20;

  function automatic int unsigned frame_bits(input int unsigned n,
                                             input int unsigned w0,
                                             input int unsigned w);
    return w0 + (n - 1) * w;
  endfunction
endpackage

// File: rtl/aclink_timing.sv
module aclink_timing #(
  parameter int unsigned FRAME_LEN = 256,
  parameter int unsigned SLOT0_W   = 16,
  parameter int unsigned CNT_W     = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  output logic [CNT_W-1:0] cnt_o,
  output logic             sync_o
);
  localparam logic [CNT_W-1:0] LAST     = CNT_W'(FRAME_LEN - 1);
  localparam logic [CNT_W-1:0] SYNC_END = CNT_W'(SLOT0_W);

  logic [CNT_W-1:0] cnt_d;
  logic             sync_d;

  always_comb begin
    if (!run) begin
      cnt_d  = '0;
      sync_d = 1'b0;
    end else begin
      cnt_d  = (cnt_o == LAST) ? '0 : cnt_o + 1'b1;
      sync_d = (cnt_o < SYNC_END);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_o  <= '0;
      sync_o <= 1'b0;
    end else begin
      cnt_o  <= cnt_d;
      sync_o <= sync_d;
    end
  end

  // R1: position wraps to zero after the last bit of a frame
  p_wrap_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (run && cnt_o == LAST) |=> (cnt_o == '0));

  // R2: sync rises only together with the start of a frame
  p_sync_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sync_o) |-> (cnt_o == CNT_W'(1)));
endmodule

// File: rtl/aclink_tx.sv
module aclink_tx #(
  parameter int unsigned FRAME_LEN = 256,
  parameter int unsigned CNT_W     = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 run,
  input  logic [CNT_W-1:0]     cnt,
  input  logic [FRAME_LEN-1:0] frame_in,
  output logic                 sdo_o
);
  logic [FRAME_LEN-1:0] sh_q, sh_d;
  logic                 sdo_d;

  always_comb begin
    sh_d  = sh_q;
    sdo_d = 1'b0;
    if (run) begin
      if (cnt == '0) begin
        sdo_d = frame_in[FRAME_LEN-1];
        sh_d  = {frame_in[FRAME_LEN-2:0], 1'b0};
      end else begin
        sdo_d = sh_q[FRAME_LEN-1];
        sh_d  = {sh_q[FRAME_LEN-2:0], 1'b0};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      sdo_o <= 1'b0;
    end else begin
      sh_q  <= sh_d;
      sdo_o <= sdo_d;
    end
  end
endmodule

// File: rtl/aclink_rx.sv
module aclink_rx #(
  parameter int unsigned FRAME_LEN = 256,
  parameter int unsigned CNT_W     = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 run,
  input  logic [CNT_W-1:0]     cnt,
  input  logic                 sdi,
  output logic [FRAME_LEN-1:0] word_o,
  output logic                 valid_o
);
  logic                 sdi_n;
  logic [FRAME_LEN-2:0] sh_q, sh_d;
  logic                 armed_q, armed_d;
  logic [FRAME_LEN-1:0] word_d;
  logic                 valid_d;

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) sdi_n <= 1'b0;
    else        sdi_n <= sdi;
  end

  always_comb begin
    sh_d    = sh_q;
    armed_d = armed_q;
    word_d  = word_o;
    valid_d = 1'b0;
    if (!run) begin
      armed_d = 1'b0;
    end else begin
      sh_d = {sh_q[FRAME_LEN-3:0], sdi_n};
      if (cnt == CNT_W'(1)) armed_d = 1'b1;
      if (cnt == '0 && armed_q) begin
        word_d  = {sh_q, sdi_n};
        valid_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q    <= '0;
      armed_q <= 1'b0;
      word_o  <= '0;
      valid_o <= 1'b0;
    end else begin
      sh_q    <= sh_d;
      armed_q <= armed_d;
      word_o  <= word_d;
      valid_o <= valid_d;
    end
  end

  // R7: publication lines up with the start of the next frame
  p_pub_at_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> (cnt == CNT_W'(1)));
endmodule

// File: rtl/aclink_frame_ser.sv
module aclink_frame_ser
  import aclink_pkg::*;
#(
  parameter int unsigned NSLOT   = DEF_NSLOT,
  parameter int unsigned SLOT0_W = DEF_SLOT0_W,
  parameter int unsigned SLOT_W  = DEF_SLOT_W,
  parameter int unsigned DATA_W  = (NSLOT - 1) * SLOT_W
) (
  input  logic              bclk,
  input  logic              rst_n,
  input  logic              link_en,
  input  logic [SLOT0_W-1:0] tx_tag,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              sdi,
  output logic              sync,
  output logic              sdo,
  output logic              codec_rst_n,
  output logic [SLOT0_W-1:0] rx_tag,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_valid
);
  localparam int unsigned FRAME_LEN = frame_bits(NSLOT, SLOT0_W, SLOT_W);
  localparam int unsigned CNT_W     = $clog2(FRAME_LEN);

  logic [1:0]           rs_q;
  logic                 rst_int_n;
  logic                 link_q;
  logic [CNT_W-1:0]     cnt;
  logic [FRAME_LEN-1:0] tx_frame;
  logic [FRAME_LEN-1:0] rx_frame;

  // asynchronous assert, synchronous release
  always_ff @(posedge bclk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_int_n = rs_q[1];

  always_ff @(posedge bclk or negedge rst_int_n) begin
    if (!rst_int_n) link_q <= 1'b0;
    else            link_q <= link_en;
  end
  assign codec_rst_n = link_q;

  assign tx_frame[FRAME_LEN-1 -: SLOT0_W] = tx_tag;
  assign rx_tag = rx_frame[FRAME_LEN-1 -: SLOT0_W];

  for (genvar k = 1; k < NSLOT; k++) begin : g_slot
    localparam int unsigned TOP = FRAME_LEN - 1 - SLOT0_W - (k - 1) * SLOT_W;
    assign tx_frame[TOP -: SLOT_W] = tx_data[(k-1)*SLOT_W +: SLOT_W];
    assign rx_data[(k-1)*SLOT_W +: SLOT_W] = rx_frame[TOP -: SLOT_W];
  end

  aclink_timing #(.FRAME_LEN(FRAME_LEN), .SLOT0_W(SLOT0_W), .CNT_W(CNT_W)) u_timing (
    .clk(bclk), .rst_n(rst_int_n), .run(link_q), .cnt_o(cnt), .sync_o(sync)
  );

  aclink_tx #(.FRAME_LEN(FRAME_LEN), .CNT_W(CNT_W)) u_tx (
    .clk(bclk), .rst_n(rst_int_n), .run(link_q), .cnt(cnt),
    .frame_in(tx_frame), .sdo_o(sdo)
  );

  aclink_rx #(.FRAME_LEN(FRAME_LEN), .CNT_W(CNT_W)) u_rx (
    .clk(bclk), .rst_n(rst_int_n), .run(link_q), .cnt(cnt), .sdi(sdi),
    .word_o(rx_frame), .valid_o(rx_valid)
  );

  // R8: a held codec reset keeps the link silent
  p_quiet_r8: assert property (@(posedge bclk) disable iff (!rst_int_n)
    !link_q |=> (!sync && !sdo));

  // R8: codec reset tracks the enable one edge later
  p_creset_follow_r8: assert property (@(posedge bclk) disable iff (!rst_int_n)
    link_en |=> codec_rst_n);

  // R7: the strobe lasts a single clock
  p_strobe_pulse_r7: assert property (@(posedge bclk) disable iff (!rst_int_n)
    rx_valid |=> !rx_valid);
endmodule

// File: tb/aclink_frame_ser_tb.sv
module aclink_frame_ser_tb;
  localparam int FL = 256;
  localparam int DW = 240;

  logic bclk = 1'b0;
  logic rst_n = 1'b0;
  logic link_en = 1'b0;
  logic [15:0] tx_tag = '0;
  logic [DW-1:0] tx_data = '0;
  logic sdi = 1'b0;
  logic sync, sdo, codec_rst_n, rx_valid;
  logic [15:0] rx_tag;
  logic [DW-1:0] rx_data;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;
  bit bnd_req = 0;

  always #5 bclk = ~bclk;

  aclink_frame_ser u_dut (
    .bclk(bclk), .rst_n(rst_n), .link_en(link_en), .tx_tag(tx_tag),
    .tx_data(tx_data), .sdi(sdi), .sync(sync), .sdo(sdo),
    .codec_rst_n(codec_rst_n), .rx_tag(rx_tag), .rx_data(rx_data),
    .rx_valid(rx_valid)
  );

  task automatic chk(input bit ok, input string req, input logic [255:0] act,
                     input logic [255:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s at %0t: actual %0h expected %0h", req, $time, act, exp);
    end
  endtask

  // frame layout from R3: tag MSB first, then slot 1..12, each MSB first
  function automatic logic [FL-1:0] pack(input logic [15:0] t, input logic [DW-1:0] d);
    logic [FL-1:0] f;
    for (int p = 0; p < FL; p++) begin
      if (p < 16) f[FL-1-p] = t[15-p];
      else f[FL-1-p] = d[((p-16)/20)*20 + 19 - (p-16)%20];
    end
    return f;
  endfunction

  // reference model and per-clock comparison
  initial begin
    logic [FL-1:0] m_frame, rxw, e_rx;
    bit q[$];
    int m_pos, rx_cnt, clk_no, last_rise, bpos;
    int blist[$];
    bit m_en, e_sync, e_sdo, e_v, prev_sync, prev_sdo, bnd_rec;
    m_frame = '0; rxw = '0; e_rx = '0;
    m_pos = 0; rx_cnt = 0; clk_no = 0; last_rise = -1; bpos = 0;
    m_en = 0; prev_sync = 0; prev_sdo = 0; bnd_rec = 0;
    forever begin
      @(posedge bclk); #1;
      clk_no++;
      if (!rst_n) begin
        m_en = 0; m_pos = 0; q.delete(); sdi = 1'b0; last_rise = -1;
        chk(!sync && !sdo && !codec_rst_n && !rx_valid && rx_tag == '0 && rx_data == '0,
            "R9 reset", {sync, sdo, codec_rst_n, rx_valid, rx_tag}, '0);
        prev_sync = 0; prev_sdo = 0;
        continue;
      end
      e_v = 0;
      if (!m_en) begin
        e_sync = 0; e_sdo = 0; m_pos = 0; q.delete(); sdi = 1'b0;
      end else begin
        if (m_pos == 0) begin
          if (q.size() == FL) begin
            e_v = 1;
            for (int i = 0; i < FL; i++) e_rx[FL-1-i] = q[i];
          end
          q.delete();
          m_frame = pack(tx_tag, tx_data);
          rxw = {8{32'h5A3C96E1 + 32'(rx_cnt) * 32'h9E3779B9}};
          rx_cnt++;
        end
        e_sync = (m_pos < 16);
        e_sdo = m_frame[FL-1-m_pos];
        sdi = rxw[FL-1-m_pos];
        q.push_back(sdi);
        m_pos = (m_pos + 1) % FL;
      end
      chk(sync == e_sync, "R2 sync level", 256'(sync), 256'(e_sync));
      chk(sdo == e_sdo, "R3 R4 R6 serial out", 256'(sdo), 256'(e_sdo));
      chk(rx_valid == e_v, "R7 strobe", 256'(rx_valid), 256'(e_v));
      if (e_v) chk(pack(rx_tag, rx_data) == e_rx, "R5 received frame",
                   pack(rx_tag, rx_data), e_rx);
      chk(codec_rst_n == link_en, "R8 codec reset", 256'(codec_rst_n), 256'(link_en));
      m_en = link_en;

      // R1 frame period and R3 boundary monitor on observed outputs
      if (!codec_rst_n) last_rise = -1;
      if (sync && !prev_sync) begin
        if (last_rise >= 0) chk(clk_no - last_rise == FL, "R1 frame period",
                                256'(clk_no - last_rise), 256'(FL));
        last_rise = clk_no;
        if (bnd_rec) begin
          bnd_rec = 0; bnd_req = 0;
          chk(blist.size() == 12, "R3 boundary count", 256'(blist.size()), 256'd12);
          for (int j = 0; j < 12 && j < blist.size(); j++)
            chk(blist[j] == 16 + 20*j, "R3 boundary position",
                256'(blist[j]), 256'(16 + 20*j));
        end else if (bnd_req) begin
          bnd_rec = 1; bpos = 0; blist.delete();
        end
      end
      if (bnd_rec) begin
        if (bpos != 0 && sdo != prev_sdo) blist.push_back(bpos);
        bpos++;
      end
      prev_sync = sync; prev_sdo = sdo;
    end
  end

  task automatic step(input int n);
    repeat (n) @(posedge bclk);
    #3;
  endtask

  function automatic logic [DW-1:0] count_slots(input int base);
    logic [DW-1:0] d;
    for (int k = 0; k < 12; k++) d[k*20 +: 20] = 20'(base + k * 20'h1111);
    return d;
  endfunction

  initial begin
    step(3);
    rst_n = 1'b1;
    step(4);
    link_en = 1'b1;                       // R8 release, R4 first bit
    tx_tag = 16'h9C35; tx_data = count_slots(20'h0A5);
    step(600);
    tx_tag = 16'hFFFF;                    // alternating slots for boundaries
    for (int k = 0; k < 12; k++) tx_data[k*20 +: 20] = ((k + 1) % 2 == 0) ? '1 : '0;
    step(300);
    bnd_req = 1'b1;
    step(700);
    while (!sync) step(1);                // R6: change mid-frame
    step(50);
    tx_tag = 16'h1234; tx_data = count_slots(20'h3C00);
    step(20);
    tx_tag = 16'hBEEF; tx_data = ~count_slots(20'h7);
    step(600);
    link_en = 1'b0;                       // R8 drop mid-frame
    step(100);
    link_en = 1'b1;
    step(700);
    link_en = 1'b0; rst_n = 1'b0;         // R9 async reset mid-run
    step(5);
    rst_n = 1'b1;
    step(5);
    link_en = 1'b1;
    step(600);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge bclk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule